// File: doc/BRIEF.md
# Serial CTS/RTS Handshake Controller

This block handles hardware flow control for one serial channel, in clock-synchronous or asynchronous framing. It drives the request-to-send level and gates transmit starts on the clear-to-send level. It also decides which role the shared handshake pin and the clock pin take. Request-to-send is a one-frame handshake. It is pulled low when the receiver is armed, either by turning reception on or by reading the low byte of the receive buffer. It returns high as soon as the receiver reports that a new frame has begun.

Configuration comes in as level bits:
- mode: synchronous or asynchronous
- clock source: internal or external
- flow-control enable
- function select, which picks CTS or RTS on the shared pin
- separate select, which moves RTS onto the clock pin and leaves the shared pin as CTS

Two combinations are unsafe:
- separation in synchronous mode, or with an external clock
- RTS while in synchronous mode with an internal clock

The block flags either combination as an error, holds RTS high and blocks transmission. The clear-to-send pin passes through a synchronizer whose depth is a parameter.

Top module: `chx_flow_ctrl`

## Requirements
- R1: While the receive-enable input is 0, `rts_n_o` is 1.
- R2: A 0-to-1 change of receive-enable arms the receiver, so `rts_n_o` reads 0 in the cycle after the change.
- R3: A single-cycle low-byte read strobe arms the receiver. With receive-enable at 1, `rts_n_o` is 0 from the cycle after the strobe.
- R4: A reception-start pulse disarms the receiver, so `rts_n_o` is 1 from the cycle after the pulse until the next arming event.
- R5: When the reception-start pulse and the read strobe arrive in the same cycle, the start pulse wins and `rts_n_o` stays 1.
- R6: While CTS is in use, `tx_permit_o` is 1 only when the synchronized CTS level is 0. A change on `cts_n_i` reaches `tx_permit_o` after CTS_SYNC_STAGES cycles.
- R7: Pin roles follow these encodings:
  - With flow control on and separation off, `shared_role_o` is 2'b01 (CTS) when function select is 0, or 2'b10 (RTS) when it is 1, and `clk_role_o` is 0 (clock).
  - With separation on, `shared_role_o` is 2'b01 and `clk_role_o` is 1 (RTS).
  - `rts_drive_o` is 1 exactly when some pin carries RTS.
- R8: With flow control off, `tx_permit_o` is 1 whatever the CTS level, `shared_role_o` is 2'b00 (general purpose), `clk_role_o` is 0 and `rts_drive_o` is 0.
- R9: With flow control on, `cfg_err_o` is 1 in either of these cases, and while it is 1, `rts_n_o` is 1 and `tx_permit_o` is 0:
  - separation is selected in synchronous mode or with an external clock
  - RTS is in use in synchronous mode with an internal clock
- R10: `tx_go_o` equals `tx_req_i` AND `tx_permit_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode_i | input | 1 | 1 = clock-synchronous framing, 0 = asynchronous |
| ext_clk_i | input | 1 | 1 = external shift clock, 0 = internal |
| fc_en_i | input | 1 | Flow-control enable |
| fn_rts_i | input | 1 | Shared pin function: 0 = CTS, 1 = RTS |
| sep_i | input | 1 | Separate CTS and RTS onto two pins |
| rx_en_i | input | 1 | Receive enable |
| rxbuf_lo_rd_i | input | 1 | Single-cycle strobe: receive buffer low byte read |
| rx_start_i | input | 1 | Single-cycle pulse: reception began |
| cts_n_i | input | 1 | Clear-to-send pin level, active low, asynchronous |
| tx_req_i | input | 1 | Transmitter wants to start a frame |
| rts_n_o | output | 1 | Request-to-send level, active low |
| rts_drive_o | output | 1 | Some pin carries RTS |
| tx_permit_o | output | 1 | Transmit start allowed |
| tx_go_o | output | 1 | Transmit start granted this cycle |
| shared_role_o | output | 2 | Shared pin role: 00 general purpose, 01 CTS, 10 RTS |
| clk_role_o | output | 1 | Clock pin role: 0 clock, 1 RTS |
| cfg_err_o | output | 1 | Unsafe configuration |

## Verification
The bench builds the block with its default CTS_SYNC_STAGES of 2. This makes the two-cycle synchronizer delay observable: a CTS edge must leave `tx_permit_o` unchanged for one sample and flip it on the next. With that depth, each arming and disarming event and each configuration change can be checked at a fixed cycle offset. This covers the start-versus-read collision and both unsafe configuration classes.

// File: rtl/chx_pkg.sv
package chx_pkg;

    typedef enum logic [1:0] {
        SH_GPIO = 2'b00,
        SH_CTS  = 2'b01,
        SH_RTS  = 2'b10
    } shared_role_e;

    typedef enum logic {
        CK_CLOCK = 1'b0,
        CK_RTS   = 1'b1
    } clk_role_e;

    typedef struct packed {
        logic sync_mode;
        logic ext_clk;
        logic fc_en;
        logic fn_rts;
        logic sep;
    } fc_cfg_t;

    typedef struct packed {
        shared_role_e shared;
        clk_role_e    clkpin;
        logic         cts_used;
        logic         rts_used;
        logic         illegal;
    } role_t;

    function automatic role_t decode_roles(fc_cfg_t c);
        role_t r;
        r.shared   = SH_GPIO;
        r.clkpin   = CK_CLOCK;
        r.cts_used = 1'b0;
        r.rts_used = 1'b0;
        r.illegal  = 1'b0;
        if (c.fc_en) begin
            if (c.sep) begin
                r.shared   = SH_CTS;
                r.clkpin   = CK_RTS;
                r.cts_used = 1'b1;
                r.rts_used = 1'b1;
                r.illegal  = c.sync_mode | c.ext_clk;
            end else if (c.fn_rts) begin
                r.shared   = SH_RTS;
                r.rts_used = 1'b1;
                r.illegal  = c.sync_mode & ~c.ext_clk;
            end else begin
                r.shared   = SH_CTS;
                r.cts_used = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/chx_role_decode.sv
module chx_role_decode
    import chx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fc_cfg_t cfg,
    output role_t   roles
);

    always_comb roles = decode_roles(cfg);

    AST_ONE_RTS_PIN: assert property (@(posedge clk) disable iff (rst)
        $onehot0({roles.shared == SH_RTS, roles.clkpin == CK_RTS})) else $error("two RTS pins"); // R7

    AST_NOFC_GPIO: assert property (@(posedge clk) disable iff (rst)
        !cfg.fc_en |-> (roles.shared == SH_GPIO && roles.clkpin == CK_CLOCK)) else $error("roles without fc"); // R8

endmodule

// File: rtl/chx_cts_sync.sv
module chx_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES:0] chain;
    assign chain[0] = d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i+1] <= 1'b1;
            else     chain[i+1] <= chain[i];
        end
    end

    assign q = chain[STAGES];

endmodule

// File: rtl/chx_rts_track.sv
module chx_rts_track (
    input  logic clk,
    input  logic rst,
    input  logic rx_en,
    input  logic buf_rd,
    input  logic rx_start,
    output logic armed
);

    logic rx_en_q;
    logic arm_evt;

    assign arm_evt = (rx_en & ~rx_en_q) | buf_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en_q <= 1'b0;
            armed   <= 1'b0;
        end else begin
            rx_en_q <= rx_en;
            if (rx_start)     armed <= 1'b0;
            else if (arm_evt) armed <= 1'b1;
        end
    end

    AST_START_DISARMS: assert property (@(posedge clk) disable iff (rst)
        rx_start |=> !armed) else $error("start did not disarm"); // R4 R5

    AST_READ_ARMS: assert property (@(posedge clk) disable iff (rst)
        (buf_rd && !rx_start) |=> armed) else $error("read did not arm"); // R3

endmodule

// File: rtl/chx_flow_ctrl.sv
module chx_flow_ctrl
    import chx_pkg::*;
#(
    parameter int CTS_SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_mode_i,
    input  logic       ext_clk_i,
    input  logic       fc_en_i,
    input  logic       fn_rts_i,
    input  logic       sep_i,
    input  logic       rx_en_i,
    input  logic       rxbuf_lo_rd_i,
    input  logic       rx_start_i,
    input  logic       cts_n_i,
    input  logic       tx_req_i,
    output logic       rts_n_o,
    output logic       rts_drive_o,
    output logic       tx_permit_o,
    output logic       tx_go_o,
    output logic [1:0] shared_role_o,
    output logic       clk_role_o,
    output logic       cfg_err_o
);

    fc_cfg_t cfg;
    role_t   roles;
    logic    armed;
    logic    cts_s;

    always_comb begin
        cfg.sync_mode = sync_mode_i;
        cfg.ext_clk   = ext_clk_i;
        cfg.fc_en     = fc_en_i;
        cfg.fn_rts    = fn_rts_i;
        cfg.sep       = sep_i;
    end

    chx_role_decode u_roles (
        .clk   (clk),
        .rst   (rst),
        .cfg   (cfg),
        .roles (roles)
    );

    chx_rts_track u_track (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (rx_en_i),
        .buf_rd   (rxbuf_lo_rd_i),
        .rx_start (rx_start_i),
        .armed    (armed)
    );

    chx_cts_sync #(.STAGES(CTS_SYNC_STAGES)) u_cts (
        .clk (clk),
        .rst (rst),
        .d   (cts_n_i),
        .q   (cts_s)
    );

    always_comb begin
        cfg_err_o     = roles.illegal;
        rts_n_o       = roles.illegal | ~(rx_en_i & armed);
        rts_drive_o   = roles.rts_used;
        shared_role_o = roles.shared;
        clk_role_o    = roles.clkpin;
        if (roles.illegal)       tx_permit_o = 1'b0;
        else if (roles.cts_used) tx_permit_o = ~cts_s;
        else                     tx_permit_o = 1'b1;
        tx_go_o = tx_req_i & tx_permit_o;
    end

    AST_RXOFF_RTS_HIGH: assert property (@(posedge clk) disable iff (rst)
        !rx_en_i |-> rts_n_o) else $error("rts low while rx off"); // R1

    AST_TX_NEEDS_CTS: assert property (@(posedge clk) disable iff (rst)
        (roles.cts_used && tx_go_o) |-> !cts_s) else $error("tx without cts"); // R6

    AST_NOFC_PERMIT: assert property (@(posedge clk) disable iff (rst)
        !fc_en_i |-> tx_permit_o) else $error("tx blocked without fc"); // R8

    AST_ERR_SAFE: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |-> (rts_n_o && !tx_permit_o)) else $error("unsafe cfg not held"); // R9

    AST_GO_GATED: assert property (@(posedge clk) disable iff (rst)
        tx_go_o |-> (tx_req_i && tx_permit_o)) else $error("go without req/permit"); // R10

endmodule

// File: tb/chx_flow_ctrl_tb_top.sv
module chx_flow_ctrl_tb_top;

    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_mode_i = 0, ext_clk_i = 0, fc_en_i = 0, fn_rts_i = 0, sep_i = 0;
    logic rx_en_i = 0, rxbuf_lo_rd_i = 0, rx_start_i = 0, cts_n_i = 1, tx_req_i = 0;
    logic rts_n_o, rts_drive_o, tx_permit_o, tx_go_o, clk_role_o, cfg_err_o;
    logic [1:0] shared_role_o;

    always #10 clk = ~clk;

    chx_flow_ctrl #(.CTS_SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .rst(rst), .sync_mode_i(sync_mode_i), .ext_clk_i(ext_clk_i),
        .fc_en_i(fc_en_i), .fn_rts_i(fn_rts_i), .sep_i(sep_i), .rx_en_i(rx_en_i),
        .rxbuf_lo_rd_i(rxbuf_lo_rd_i), .rx_start_i(rx_start_i), .cts_n_i(cts_n_i),
        .tx_req_i(tx_req_i), .rts_n_o(rts_n_o), .rts_drive_o(rts_drive_o),
        .tx_permit_o(tx_permit_o), .tx_go_o(tx_go_o), .shared_role_o(shared_role_o),
        .clk_role_o(clk_role_o), .cfg_err_o(cfg_err_o)
    );

    typedef enum int {S_RTS, S_PERMIT, S_GO, S_SHARED, S_CLKR, S_ERR, S_DRIVE} sig_e;
    typedef struct {
        int    cyc;
        string req;
        sig_e  sig;
        int    val;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    function automatic int peek(sig_e s);
        case (s)
            S_RTS:    return int'(rts_n_o);
            S_PERMIT: return int'(tx_permit_o);
            S_GO:     return int'(tx_go_o);
            S_SHARED: return int'(shared_role_o);
            S_CLKR:   return int'(clk_role_o);
            S_ERR:    return int'(cfg_err_o);
            default:  return int'(rts_drive_o);
        endcase
    endfunction

    // driver side: queue an expected value due 'lat' samples from now
    task automatic expect_at(int lat, string req, sig_e s, int v);
        exp_t e;
        e.cyc = cyc + lat;
        e.req = req;
        e.sig = s;
        e.val = v;
        sb.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: samples 5 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            cyc++;
            while (sb.size() > 0 && sb[0].cyc <= cyc) begin
                exp_t e;
                int   a;
                e = sb.pop_front();
                a = peek(e.sig);
                n_chk++;
                if (a !== e.val) begin
                    n_fail++;
                    $display("FAIL %s sig=%s actual=%0d expected=%0d cycle=%0d",
                             e.req, e.sig.name(), a, e.val, cyc);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        // reset state, flow control off
        expect_at(1, "R1", S_RTS, 1);
        expect_at(1, "R8", S_PERMIT, 1);
        expect_at(1, "R8", S_SHARED, 0);
        expect_at(1, "R8", S_DRIVE, 0);
        expect_at(1, "R9", S_ERR, 0);
        tick(3);

        // RTS on shared pin, asynchronous, internal clock
        fc_en_i = 1; fn_rts_i = 1;
        expect_at(1, "R7", S_SHARED, 2);
        expect_at(1, "R7", S_CLKR, 0);
        expect_at(1, "R7", S_DRIVE, 1);
        expect_at(1, "R1", S_RTS, 1);
        tick(2);

        // enable reception: arms
        rx_en_i = 1;
        expect_at(1, "R2", S_RTS, 0);
        tick(3);

        // reception starts: RTS back high and stays
        rx_start_i = 1; tick(1); rx_start_i = 0;
        expect_at(0, "R4", S_RTS, 1);
        expect_at(3, "R4", S_RTS, 1);
        tick(4);

        // buffer read re-arms
        rxbuf_lo_rd_i = 1; tick(1); rxbuf_lo_rd_i = 0;
        expect_at(0, "R3", S_RTS, 0);
        tick(3);

        // collision: start wins
        rxbuf_lo_rd_i = 1; rx_start_i = 1; tick(1);
        rxbuf_lo_rd_i = 0; rx_start_i = 0;
        expect_at(0, "R5", S_RTS, 1);
        expect_at(2, "R5", S_RTS, 1);
        tick(3);

        // re-arm then disable reception
        rxbuf_lo_rd_i = 1; tick(1); rxbuf_lo_rd_i = 0;
        expect_at(0, "R3", S_RTS, 0);
        tick(2);
        rx_en_i = 0;
        expect_at(1, "R1", S_RTS, 1);
        tick(2);

        // CTS on shared pin
        fn_rts_i = 0; tx_req_i = 1;
        expect_at(1, "R7", S_SHARED, 1);
        expect_at(1, "R7", S_DRIVE, 0);
        expect_at(1, "R6", S_PERMIT, 0);
        expect_at(1, "R10", S_GO, 0);
        tick(3);
        cts_n_i = 0;
        expect_at(1, "R6", S_PERMIT, 0);
        expect_at(SYNC, "R6", S_PERMIT, 1);
        expect_at(SYNC, "R10", S_GO, 1);
        tick(SYNC + 1);
        tx_req_i = 0;
        expect_at(1, "R10", S_GO, 0);
        tick(2);

        // separation, legal (async, internal clock)
        sep_i = 1;
        expect_at(1, "R7", S_SHARED, 1);
        expect_at(1, "R7", S_CLKR, 1);
        expect_at(1, "R7", S_DRIVE, 1);
        expect_at(1, "R9", S_ERR, 0);
        expect_at(1, "R6", S_PERMIT, 1);
        tick(2);
        rx_en_i = 1;
        expect_at(1, "R2", S_RTS, 0);
        tick(2);

        // separation in synchronous mode: unsafe
        sync_mode_i = 1;
        expect_at(1, "R9", S_ERR, 1);
        expect_at(1, "R9", S_RTS, 1);
        expect_at(1, "R9", S_PERMIT, 0);
        tick(2);
        // separation with external clock, async: still unsafe
        sync_mode_i = 0; ext_clk_i = 1;
        expect_at(1, "R9", S_ERR, 1);
        tick(2);

        // RTS on shared pin, synchronous, internal clock: unsafe
        sep_i = 0; fn_rts_i = 1; sync_mode_i = 1; ext_clk_i = 0;
        expect_at(1, "R9", S_ERR, 1);
        expect_at(1, "R9", S_RTS, 1);
        tick(2);
        // external clock makes it legal; receiver still armed
        ext_clk_i = 1;
        expect_at(1, "R9", S_ERR, 0);
        expect_at(1, "R3", S_RTS, 0);
        tick(2);

        // flow control off: permit regardless of CTS
        cts_n_i = 1; fn_rts_i = 0; sync_mode_i = 0; ext_clk_i = 0;
        tick(SYNC + 2);
        fc_en_i = 0; tx_req_i = 1;
        expect_at(1, "R8", S_PERMIT, 1);
        expect_at(1, "R8", S_SHARED, 0);
        expect_at(1, "R8", S_CLKR, 0);
        expect_at(1, "R8", S_DRIVE, 0);
        expect_at(1, "R10", S_GO, 1);
        tick(3);

        wait (sb.size() == 0);
        tick(1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule